// File: doc/BRIEF.md
# Soft Mute Gain Ramp Controller

This block sits in a stereo audio path, ahead of the conversion stages. It scales a pair of 24-bit two's-complement samples by a gain word, once per sample frame. A mute request can come from a register bit or from a pin. While the request is active, the gain falls in a straight line to zero. When the request is dropped, the gain climbs back to unity. The ramp length is counted in frames and is set by a 2-bit rate mode. The same length applies in both directions. A request that reverses mid-ramp turns the ramp around at the gain it has reached.

The block also drives an active-low status line for an external analog mute circuit. The line falls only once a mute ramp has reached zero gain. It rises again as soon as the request is dropped. It is forced low while reset is applied, during power-down, while the clock-ratio fault flag is raised, and from reset or power-down until the first frame strobe arrives. After reset or power-down the gain starts at zero, so the stream fades in.

Top module: `soft_mute_ramp`

## Requirements
- R1: The mute request is the OR of `mute_reg` and `mute_pin`. Either source on its own starts a downward ramp, and the ramp moves one step per `frame_stb` pulse.
- R2: A full ramp in either direction takes 1152 strobes in rate mode 0, 2304 in mode 1, and 4608 in modes 2 and 3. The gain changes by at most 4 units per strobe.
- R3: The gain word runs from 0 (silence) to 4608 (unity). It never exceeds 4608, and it changes only on a strobe or on power-down.
- R4: On each strobe, each output is loaded with the input sample times the gain held before that strobe, divided by 4608 and truncated toward zero. At unity the output equals the input exactly. At zero gain it is exactly 0.
- R5: If the request reverses mid-ramp, the gain continues from its current value in the new direction. It does not restart from an end point.
- R6: A rate-mode change takes effect at the next strobe and keeps the current gain. A step that would pass 0 or 4608 stops at that end.
- R7: While a request is active, `mute_n` goes low one clock after the gain register reaches 0, and not before.
- R8: When both request sources drop and no fault is present, `mute_n` rises on the next clock, even while the gain is still 0.
- R9: `mute_n` is low while reset is applied, while `pwr_down` or `ratio_err` is high, and from reset or power-down release until the first strobe.
- R10: `pwr_down` clears the gain and both outputs on the next clock. After release, the gain ramps up from 0.
- R11: Reset clears both outputs and the gain. After reset the gain rises from 0 as a fade-in.
- R12: `ratio_err` affects only `mute_n`. Gain stepping and output scaling carry on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_stb | input | 1 | One-clock pulse per sample frame |
| rate_mode | input | 2 | Rate mode selecting the ramp length |
| mute_reg | input | 1 | Mute request from a register bit |
| mute_pin | input | 1 | Mute request from a pin |
| pwr_down | input | 1 | Power-down request |
| ratio_err | input | 1 | Clock-ratio fault flag |
| left_in | input | 24 | Left input sample, two's complement |
| right_in | input | 24 | Right input sample, two's complement |
| left_out | output | 24 | Scaled left sample |
| right_out | output | 24 | Scaled right sample |
| mute_n | output | 1 | Active-low mute status for an external mute circuit |

## Verification
The gain register is observable one strobe later, because each output sample is the input multiplied by the gain held before that strobe. A wrong step size or a missed saturation therefore shows up as a wrong output value at the very next frame. An off-by-one in the ramp length moves the fall of `mute_n` by one frame, so the bench checks every frame of every ramp against an independent model of the gain. A status path that ignores a fault, the init window or the unmute release is wrong on `mute_n` within one clock.

// File: rtl/sm_ramp_pkg.sv
package sm_ramp_pkg;

  typedef enum logic [1:0] {
    RATE_SINGLE   = 2'd0,
    RATE_DOUBLE   = 2'd1,
    RATE_QUAD     = 2'd2,
    RATE_QUAD_ALT = 2'd3
  } rate_mode_e;

  // Left shift applied to a unit step; faster rates use longer ramps.
  function automatic int unsigned step_shift(input logic [1:0] mode,
                                             input int unsigned max_shift);
    int unsigned lvl;
    unique case (rate_mode_e'(mode))
      RATE_SINGLE:   lvl = 0;
      RATE_DOUBLE:   lvl = 1;
      RATE_QUAD:     lvl = 2;
      RATE_QUAD_ALT: lvl = 2;
      default:       lvl = 2;
    endcase
    if (lvl > max_shift) lvl = max_shift;
    return max_shift - lvl;
  endfunction

endpackage

// File: rtl/sm_reset_sync.sv
module sm_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/sm_gain_ramp.sv
module sm_gain_ramp
  import sm_ramp_pkg::*;
#(
  parameter int unsigned GAIN_W    = 13,
  parameter int unsigned FULL      = 4608,
  parameter int unsigned MAX_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              pwr_down,
  input  logic              req,
  input  logic [1:0]        rate_mode,
  output logic [GAIN_W-1:0] gain,
  output logic              init_pend
);

  localparam logic [GAIN_W-1:0] FULL_G = GAIN_W'(FULL);

  logic [GAIN_W-1:0] step;
  logic [GAIN_W-1:0] headroom;
  logic [GAIN_W-1:0] gain_q, gain_d;
  logic              init_q, init_d;

  always_comb begin
    step     = GAIN_W'(1) << step_shift(rate_mode, MAX_SHIFT);
    headroom = FULL_G - gain_q;
  end

  // next-state
  always_comb begin
    gain_d = gain_q;
    init_d = init_q;
    if (pwr_down) begin
      gain_d = '0;
      init_d = 1'b1;
    end else if (adv) begin
      init_d = 1'b0;
      if (req) begin
        if (gain_q <= step) gain_d = '0;
        else                gain_d = gain_q - step;
      end else begin
        if (headroom <= step) gain_d = FULL_G;
        else                  gain_d = gain_q + step;
      end
    end
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q <= '0;
      init_q <= 1'b1;
    end else begin
      gain_q <= gain_d;
      init_q <= init_d;
    end
  end

  assign gain      = gain_q;
  assign init_pend = init_q;

endmodule

// File: rtl/sm_chan_scale.sv
module sm_chan_scale #(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned GAIN_W = 13,
  parameter int unsigned FULL   = 4608
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic                     clear,
  input  logic signed [DATA_W-1:0] sample_in,
  input  logic        [GAIN_W-1:0] gain,
  output logic signed [DATA_W-1:0] sample_out
);

  localparam int unsigned PROD_W = DATA_W + GAIN_W + 1;
  localparam logic signed [PROD_W-1:0] FULL_S = PROD_W'(FULL);

  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] quot;
  logic signed [DATA_W-1:0] out_q, out_d;

  always_comb begin
    prod = PROD_W'(sample_in) * PROD_W'($signed({1'b0, gain}));
    // signed division truncates toward zero
    quot = prod / FULL_S;
  end

  // next-state
  always_comb begin
    out_d = out_q;
    if (clear)     out_d = '0;
    else if (load) out_d = quot[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_d;
  end

  assign sample_out = out_q;

endmodule

// File: rtl/sm_mute_status.sv
module sm_mute_status (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_down,
  input  logic ratio_err,
  input  logic init_pend,
  input  logic req,
  input  logic gain_zero,
  output logic mute_n
);

  logic stat_q, stat_d;

  // next-state: low for faults, the init window, or a completed mute
  always_comb begin
    stat_d = ~(pwr_down | ratio_err | init_pend | (req & gain_zero));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= 1'b0;
    else        stat_q <= stat_d;
  end

  assign mute_n = stat_q;

endmodule

// File: rtl/soft_mute_ramp.sv
module soft_mute_ramp #(
  parameter int unsigned DATA_W      = 24,
  parameter int unsigned BASE_FRAMES = 1152,
  parameter int unsigned MAX_SHIFT   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     frame_stb,
  input  logic [1:0]               rate_mode,
  input  logic                     mute_reg,
  input  logic                     mute_pin,
  input  logic                     pwr_down,
  input  logic                     ratio_err,
  input  logic signed [DATA_W-1:0] left_in,
  input  logic signed [DATA_W-1:0] right_in,
  output logic signed [DATA_W-1:0] left_out,
  output logic signed [DATA_W-1:0] right_out,
  output logic                     mute_n
);

  localparam int unsigned FULL   = BASE_FRAMES << MAX_SHIFT;
  localparam int unsigned GAIN_W = $clog2(FULL + 1);
  localparam int unsigned NUM_CH = 2;

  logic              rst_sync_n;
  logic              req;
  logic [GAIN_W-1:0] gain_q;
  logic              init_pend;

  logic signed [DATA_W-1:0] ch_in  [NUM_CH];
  logic signed [DATA_W-1:0] ch_out [NUM_CH];

  assign req      = mute_reg | mute_pin;
  assign ch_in[0] = left_in;
  assign ch_in[1] = right_in;

  sm_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sm_gain_ramp #(
    .GAIN_W    (GAIN_W),
    .FULL      (FULL),
    .MAX_SHIFT (MAX_SHIFT)
  ) u_ramp (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .adv       (frame_stb),
    .pwr_down  (pwr_down),
    .req       (req),
    .rate_mode (rate_mode),
    .gain      (gain_q),
    .init_pend (init_pend)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    sm_chan_scale #(
      .DATA_W (DATA_W),
      .GAIN_W (GAIN_W),
      .FULL   (FULL)
    ) u_scale (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .load       (frame_stb),
      .clear      (pwr_down),
      .sample_in  (ch_in[c]),
      .gain       (gain_q),
      .sample_out (ch_out[c])
    );
  end

  assign left_out  = ch_out[0];
  assign right_out = ch_out[1];

  sm_mute_status u_stat (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .pwr_down  (pwr_down),
    .ratio_err (ratio_err),
    .init_pend (init_pend),
    .req       (req),
    .gain_zero (gain_q == '0),
    .mute_n    (mute_n)
  );

endmodule

// File: rtl/sm_ramp_checker.sv
module sm_ramp_checker #(
  parameter int unsigned DATA_W   = 24,
  parameter int unsigned GAIN_W   = 13,
  parameter int unsigned FULL     = 4608,
  parameter int unsigned STEP_MAX = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     frame_stb,
  input logic                     pwr_down,
  input logic                     ratio_err,
  input logic        [GAIN_W-1:0] gain,
  input logic signed [DATA_W-1:0] left_out,
  input logic signed [DATA_W-1:0] right_out,
  input logic                     mute_n
);

  assert_gain_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    gain <= GAIN_W'(FULL));

  assert_gain_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_stb && !pwr_down) |=> $stable(gain));

  assert_step_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && !pwr_down) |=>
      (((gain >= $past(gain)) ? (gain - $past(gain)) : ($past(gain) - gain))
        <= GAIN_W'(STEP_MAX)));

  assert_fault_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_down || ratio_err) |=> !mute_n);

  // R8: a live gain with no fault always yields a released status
  assert_live_gain_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_down && !ratio_err && gain != '0) |=> mute_n);

  assert_low_needs_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mute_n |-> ($past(pwr_down) || $past(ratio_err) || $past(gain) == '0));

  assert_zero_gain_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(frame_stb) && $past(gain) == '0) |-> (left_out == '0 && right_out == '0));

  assert_pd_out_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> (left_out == '0 && right_out == '0 && gain == '0));

endmodule

bind soft_mute_ramp sm_ramp_checker #(
  .DATA_W   (DATA_W),
  .GAIN_W   (GAIN_W),
  .FULL     (FULL),
  .STEP_MAX (1 << MAX_SHIFT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .frame_stb (frame_stb),
  .pwr_down  (pwr_down),
  .ratio_err (ratio_err),
  .gain      (gain_q),
  .left_out  (left_out),
  .right_out (right_out),
  .mute_n    (mute_n)
);

// File: tb/sim_soft_mute_ramp.sv
`timescale 1ns/1ps
module sim_soft_mute_ramp;

  localparam int FULLB = 1152 * 4;

  // {left, right, expected left, expected right} at unity gain
  localparam logic [95:0] VEC [8] = '{
    {24'h7FFFFF, 24'h800000, 24'h7FFFFF, 24'h800000},
    {24'hFFFFFF, 24'h000001, 24'hFFFFFF, 24'h000001},
    {24'h123456, 24'hEDCBAA, 24'h123456, 24'hEDCBAA},
    {24'h400000, 24'hC00000, 24'h400000, 24'hC00000},
    {24'h000000, 24'h7FFFFF, 24'h000000, 24'h7FFFFF},
    {24'h800000, 24'h000000, 24'h800000, 24'h000000},
    {24'h0ABCDE, 24'hF54322, 24'h0ABCDE, 24'hF54322},
    {24'h000011, 24'hFFFFEF, 24'h000011, 24'hFFFFEF}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic frame_stb;
  logic [1:0] rate_mode;
  logic mute_reg, mute_pin, pwr_down, ratio_err;
  logic signed [23:0] left_in, right_in;
  logic signed [23:0] left_out, right_out;
  logic mute_n;

  int total = 0;
  int bad   = 0;
  int mpos  = 0;
  bit minit = 1'b1;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  soft_mute_ramp u0 (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .rate_mode(rate_mode),
    .mute_reg(mute_reg), .mute_pin(mute_pin), .pwr_down(pwr_down),
    .ratio_err(ratio_err), .left_in(left_in), .right_in(right_in),
    .left_out(left_out), .right_out(right_out), .mute_n(mute_n)
  );

  function automatic logic signed [23:0] scale(input logic signed [23:0] s, input int g);
    longint p;
    p = longint'(s) * longint'(g);
    return 24'(p / longint'(FULLB));
  endfunction

  function automatic int mstep(input logic [1:0] m);
    if (m >= 2'd2) return 1;
    if (m == 2'd1) return 2;
    return 4;
  endfunction

  function automatic logic exp_mute();
    return !(pwr_down || ratio_err || minit || ((mute_reg || mute_pin) && mpos == 0));
  endfunction

  task automatic check(input string tag, input logic signed [23:0] el, er, input logic em);
    total++;
    if (left_out !== el || right_out !== er || mute_n !== em) begin
      bad++;
      $display("FAIL %s: actual l=%0d r=%0d mute_n=%0b expected l=%0d r=%0d mute_n=%0b",
               tag, left_out, right_out, mute_n, el, er, em);
    end
  endtask

  task automatic do_frame(input logic signed [23:0] l, r, input string tag);
    logic signed [23:0] el, er;
    @(negedge clk);
    left_in = l; right_in = r; frame_stb = 1'b1;
    el = scale(l, mpos);
    er = scale(r, mpos);
    if (mute_reg || mute_pin) mpos = (mpos <= mstep(rate_mode)) ? 0 : mpos - mstep(rate_mode);
    else mpos = (FULLB - mpos <= mstep(rate_mode)) ? FULLB : mpos + mstep(rate_mode);
    minit = 1'b0;
    @(negedge clk);
    frame_stb = 1'b0;
    @(negedge clk);
    check(tag, el, er, exp_mute());
  endtask

  task automatic run_frames(input int n, input string tag);
    for (int i = 0; i < n; i++)
      do_frame(VEC[i % 8][95:72], VEC[i % 8][71:48], tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; frame_stb = 1'b0; rate_mode = 2'd0;
    mute_reg = 1'b0; mute_pin = 1'b0; pwr_down = 1'b0; ratio_err = 1'b0;
    left_in = '0; right_in = '0;
    repeat (3) @(negedge clk);
    check("R11 reset state", 24'sd0, 24'sd0, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 init window before first strobe", 24'sd0, 24'sd0, 1'b0);

    // R11 R2: fade-in from zero in mode 0, 1152 frames
    run_frames(1152, "R11 R2 mode0 fade-in");
    total++;
    if (mpos != FULLB) begin bad++; $display("FAIL R2: actual gain=%0d expected=%0d", mpos, FULLB); end

    // R4: stimulus table at unity gain
    for (int i = 0; i < 8; i++) begin
      do_frame(VEC[i][95:72], VEC[i][71:48], "R4 table");
      total++;
      if (left_out !== VEC[i][47:24] || right_out !== VEC[i][23:0]) begin
        bad++;
        $display("FAIL R4 unity: actual l=%0d r=%0d expected l=%0d r=%0d",
                 left_out, right_out, $signed(VEC[i][47:24]), $signed(VEC[i][23:0]));
      end
    end

    // R12 R9: ratio fault only drops the status line
    @(negedge clk); ratio_err = 1'b1;
    run_frames(3, "R12 ratio fault");
    @(negedge clk); ratio_err = 1'b0;
    @(negedge clk);
    check("R9 ratio fault cleared", left_out, right_out, 1'b1);

    // R1 R2 R7: register mute, mode 1, exact 2304 frames
    rate_mode = 2'd1; mute_reg = 1'b1;
    run_frames(2304, "R1 R2 R7 mode1 mute");
    run_frames(4, "R4 muted zero");

    // R8: release raises status at once while gain still 0
    @(negedge clk); mute_reg = 1'b0;
    @(negedge clk);
    check("R8 immediate release", 24'sd0, 24'sd0, 1'b1);
    run_frames(2304, "R2 mode1 unmute");

    // R1 R5 R6: pin mute in mode 2, reverse, change mode, saturate
    rate_mode = 2'd2; mute_pin = 1'b1;
    run_frames(100, "R1 pin mute mode2");
    mute_pin = 1'b0;
    run_frames(40, "R5 reversal");
    rate_mode = 2'd0;
    run_frames(20, "R6 mode change saturate");
    total++;
    if (mpos != FULLB) begin bad++; $display("FAIL R6: actual gain=%0d expected=%0d", mpos, FULLB); end

    // R2: mode 3 uses the mode 2 length
    rate_mode = 2'd3; mute_reg = 1'b1;
    run_frames(4608, "R2 R7 mode3 mute");

    // R6 R7: short climb then fast mode down saturates at zero
    mute_reg = 1'b0; rate_mode = 2'd2;
    run_frames(3, "R5 climb from zero");
    mute_reg = 1'b1; rate_mode = 2'd0;
    run_frames(1, "R6 R7 saturate to zero");

    // R10 R9: power-down
    mute_reg = 1'b0;
    run_frames(10, "R10 pre power-down");
    @(negedge clk); pwr_down = 1'b1; mpos = 0; minit = 1'b1;
    @(negedge clk);
    check("R10 power-down clears", 24'sd0, 24'sd0, 1'b0);
    pwr_down = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 init after power-down", 24'sd0, 24'sd0, 1'b0);
    run_frames(6, "R10 ramp after power-down");

    // R11: asynchronous reset mid-stream
    @(negedge clk); rst_n = 1'b0;
    #1;
    check("R11 async reset", 24'sd0, 24'sd0, 1'b0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule